// File: doc/BRIEF.md
# Triggered Sweep Holdoff Sequencer

This block sequences one triggered sweep after another. After each sweep it holds the main trigger unit and the main sweep generator in reset. It keeps them there until a programmed number of sweep ramps has completed. It then releases both by driving its holdoff output low.

Once released, it waits for the trigger unit to report a trigger on an active-low status line. It then waits for the sweep generator's active-low sweep gate to fall, which marks the start of a sweep, and then to rise, which marks the end of the sweep. When the gate rises, the sequencer raises holdoff again and a new holdoff period begins.

A second, delayed trigger channel has its own holdoff output. That output stays high until the main sweep's active-low delay gate asserts during a triggered or sweeping cycle. Every input is asynchronous to the clock and passes through a synchronizer before any decision is made.

The ramp count limit is a plain configuration strobe with no back-pressure. It is accepted only while the sequencer is in holdoff or reset, and dropped in any other state. No data stream crosses the block boundary, so there is no valid/ready interface.

Top module: `swp_holdoff_seq`

## Requirements
- R1: While holding off with a limit value N, the holdoff output `hold_o` (1 = holding) stays high for the first N rising edges of `ramp_i`. A limit of 0 therefore ends holdoff on the first ramp edge.
- R2: The (N+1)th rising edge of `ramp_i` during holdoff drives `hold_o` low, which arms the trigger and sweep units.
- R3: While armed, a low level on `trig_stat_n_i` moves the sequencer to the triggered state and `hold_o` stays low. Further ramp edges after arming have no effect on `hold_o`.
- R4: A falling edge of `sweep_gate_n_i` starts the sweep only after a trigger has been seen. A low pulse on the sweep gate while armed and untriggered leaves `hold_o` low and the sequencer armed.
- R5: A rising edge of `sweep_gate_n_i` during a sweep drives `hold_o` high and restarts the ramp count from zero.
- R6: In the triggered or sweeping state, a low level on `delay_gate_n_i` drives `hold_b_o` low. `hold_b_o` returns high when `hold_o` rises.
- R7: `delay_gate_n_i` low while holding off or armed (before a trigger) leaves `hold_b_o` high.
- R8: A `cfg_load_i` strobe updates the ramp limit from `cfg_ramps_i` and clears the ramp count, but only while in reset or holdoff. A strobe in any other state is ignored and the old limit stays in use.
- R9: During and after reset, `hold_o` and `hold_b_o` are both high, and the ramp count and the limit are zero.
- R10: Each input passes through a two-flop synchronizer. An input edge changes the outputs on the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ramps_i | input | CNT_W | Ramp limit N for holdoff |
| cfg_load_i | input | 1 | Load strobe for the ramp limit |
| ramp_i | input | 1 | Ramp-complete indication; a rising edge counts as one ramp |
| trig_stat_n_i | input | 1 | Trigger status, low = triggered |
| sweep_gate_n_i | input | 1 | Sweep gate, low = sweep in progress |
| delay_gate_n_i | input | 1 | Delay gate, low = delayed trigger may run |
| hold_o | output | 1 | Main holdoff, high = trigger and sweep held in reset |
| hold_b_o | output | 1 | Second-channel holdoff, high = delayed trigger held in reset |

## Verification
The assertions assume that each asynchronous input holds every level for at least two clock periods, so the synchronizer never swallows a pulse. They also assume the peripheral order that a real sweep loop produces: trigger status is released before the sweep gate rises. The bench keeps every input level steady for three or more cycles and releases trigger status before it ends each sweep. It also injects the out-of-order stimuli that must be ignored (an early sweep gate, an early delay gate, ramps after arming, late configuration loads), each kept to the same minimum pulse width.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_HOLD  = 3'd1,
    ST_ARMED = 3'd2,
    ST_TRIG  = 3'd3,
    ST_SWEEP = 3'd4
  } seq_state_e;

  // bit positions in the synchronized input vector
  localparam int unsigned IN_RAMP = 0;
  localparam int unsigned IN_TRIG = 1;
  localparam int unsigned IN_SG   = 2;
  localparam int unsigned IN_DG   = 3;
  localparam int unsigned IN_W    = 4;
endpackage

// File: rtl/swseq_sync.sv
module swseq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stg[STAGES-1];
  end

  assign sync_o = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
  assign fall_o = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/swseq_ramp_cnt.sv
module swseq_ramp_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             ramp_edge,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             ramp_done
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit_q <= '0;
    else if (load_i) limit_q <= load_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!count_en || load_i)   cnt_q <= '0;
    else if (ramp_edge && !ramp_done) cnt_q <= cnt_q + 1'b1;
  end

  assign ramp_done = count_en && !load_i && ramp_edge && (cnt_q == limit_q);

  AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(limit_q)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_q); // R1
endmodule

// File: rtl/swseq_fsm.sv
module swseq_fsm
  import swseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ramp_done,
  input  logic trig_low,
  input  logic sg_fall,
  input  logic sg_rise,
  input  logic dg_low,
  output logic count_en,
  output logic cfg_ok,
  output logic hold_o,
  output logic hold_b_o
);
  seq_state_e st_q, st_d;
  logic hold_q, hold_b_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RESET: st_d = ST_HOLD;
      ST_HOLD:  if (ramp_done) st_d = ST_ARMED;
      ST_ARMED: if (trig_low)  st_d = ST_TRIG;
      ST_TRIG:  if (sg_fall)   st_d = ST_SWEEP;
      ST_SWEEP: if (sg_rise)   st_d = ST_HOLD;
      default:  st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RESET;
      hold_q   <= 1'b1;
      hold_b_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      hold_q <= (st_d == ST_RESET) || (st_d == ST_HOLD);
      if ((st_d == ST_RESET) || (st_d == ST_HOLD))
        hold_b_q <= 1'b1;
      else if (dg_low && ((st_q == ST_TRIG) || (st_q == ST_SWEEP)))
        hold_b_q <= 1'b0;
    end
  end

  assign count_en = (st_q == ST_HOLD);
  assign cfg_ok   = (st_q == ST_HOLD) || (st_q == ST_RESET);
  assign hold_o   = hold_q;
  assign hold_b_o = hold_b_q;

  AST_ARM_NEEDS_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(ramp_done)); // R2
  AST_REHOLD_NEEDS_SG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(sg_rise)); // R5
  AST_TRIG_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIG && $past(st_q) == ST_ARMED) |-> $past(trig_low)); // R3
  AST_SWEEP_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SWEEP && $past(st_q) != ST_SWEEP) |-> ($past(st_q) == ST_TRIG && $past(sg_fall))); // R4
  AST_BHOLD_UNDER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_b_q |-> !hold_q); // R6
  AST_BHOLD_NEEDS_DG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_b_q) |-> $past(dg_low)); // R7
endmodule

// File: rtl/swp_holdoff_seq.sv
module swp_holdoff_seq
  import swseq_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_ramps_i,
  input  logic             cfg_load_i,
  input  logic             ramp_i,
  input  logic             trig_stat_n_i,
  input  logic             sweep_gate_n_i,
  input  logic             delay_gate_n_i,
  output logic             hold_o,
  output logic             hold_b_o
);
  localparam logic [IN_W-1:0] IN_IDLE = 4'b1110;

  logic [IN_W-1:0] raw, s_lvl, s_rise, s_fall;
  logic count_en, cfg_ok, ramp_done;

  assign raw[IN_RAMP] = ramp_i;
  assign raw[IN_TRIG] = trig_stat_n_i;
  assign raw[IN_SG]   = sweep_gate_n_i;
  assign raw[IN_DG]   = delay_gate_n_i;

  swseq_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw),
    .sync_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall)
  );

  swseq_ramp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en),
    .ramp_edge(s_rise[IN_RAMP]),
    .load_i(cfg_load_i && cfg_ok), .load_val_i(cfg_ramps_i),
    .ramp_done(ramp_done)
  );

  swseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ramp_done(ramp_done),
    .trig_low(!s_lvl[IN_TRIG]),
    .sg_fall(s_fall[IN_SG]),
    .sg_rise(s_rise[IN_SG]),
    .dg_low(!s_lvl[IN_DG]),
    .count_en(count_en), .cfg_ok(cfg_ok),
    .hold_o(hold_o), .hold_b_o(hold_b_o)
  );

  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o == 1'b0) |-> !cfg_ok); // R9
endmodule

// File: tb/swp_holdoff_seq_tb.sv
module swp_holdoff_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_ramps = '0;
  logic cfg_load = 1'b0, ramp = 1'b0;
  logic trig_n = 1'b1, sg_n = 1'b1, dg_n = 1'b1;
  logic hold, hold_b;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  swp_holdoff_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ramps_i(cfg_ramps), .cfg_load_i(cfg_load),
    .ramp_i(ramp), .trig_stat_n_i(trig_n), .sweep_gate_n_i(sg_n),
    .delay_gate_n_i(dg_n), .hold_o(hold), .hold_b_o(hold_b)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [3:0] v);
    @(negedge clk); cfg_ramps = v; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
    wait_n(2);
  endtask

  task automatic pulse_ramp();
    ramp = 1'b1; wait_n(3);
    ramp = 1'b0; wait_n(3);
  endtask

  task automatic run_sweep();
    trig_n = 1'b0; wait_n(4);
    sg_n = 1'b0;   wait_n(4);
    trig_n = 1'b1; wait_n(3);
    sg_n = 1'b1;   wait_n(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    chk(hold, 1'b1, "R9 hold in reset");
    chk(hold_b, 1'b1, "R9 hold_b in reset");
    rst_n = 1'b1;
    wait_n(3);
    chk(hold, 1'b1, "R9 hold after reset");
    for (int n = 0; n < 16; n++) begin
      load(n[3:0]);
      for (int k = 0; k < n; k++) pulse_ramp();
      chk(hold, 1'b1, $sformatf("R1 after %0d ramps, N=%0d", n, n));
      ramp = 1'b1; wait_n(2);
      chk(hold, 1'b1, "R10 two edges after final ramp");
      wait_n(1);
      chk(hold, 1'b0, $sformatf("R2 armed at ramp %0d", n + 1));
      ramp = 1'b0; wait_n(3);
      pulse_ramp();
      chk(hold, 1'b0, "R3 ramp after arm ignored");
      dg_n = 1'b0; wait_n(4);
      chk(hold_b, 1'b1, "R7 delay gate before trigger");
      dg_n = 1'b1; wait_n(3);
      sg_n = 1'b0; wait_n(4); sg_n = 1'b1; wait_n(4);
      chk(hold, 1'b0, "R4 sweep gate before trigger");
      trig_n = 1'b0; wait_n(4);
      sg_n = 1'b0; wait_n(4);
      chk(hold, 1'b0, "R3 hold low while sweeping");
      chk(hold_b, 1'b1, "R6 hold_b high before delay gate");
      dg_n = 1'b0; wait_n(4);
      chk(hold_b, 1'b0, "R6 hold_b released by delay gate");
      trig_n = 1'b1; wait_n(3);
      sg_n = 1'b1; wait_n(3);
      chk(hold, 1'b1, "R5 hold rises at sweep end");
      chk(hold_b, 1'b1, "R6 hold_b rises with hold");
      dg_n = 1'b1; wait_n(3);
    end
    // late configuration ignored
    load(4'd2);
    for (int k = 0; k < 3; k++) pulse_ramp();
    chk(hold, 1'b0, "R2 armed with limit 2");
    load(4'd9);
    run_sweep();
    chk(hold, 1'b1, "R5 back in holdoff");
    pulse_ramp(); pulse_ramp();
    chk(hold, 1'b1, "R8 old limit still holding");
    pulse_ramp();
    chk(hold, 1'b0, "R8 load while armed ignored");
    run_sweep();
    // reload in holdoff clears partial count
    load(4'd5);
    pulse_ramp(); pulse_ramp();
    load(4'd1);
    pulse_ramp();
    chk(hold, 1'b1, "R8 reload cleared count");
    pulse_ramp();
    chk(hold, 1'b0, "R8 new limit applied");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule